// File: doc/BRIEF.md
# Serial Dual-Bridge Configuration Register

This block is the configuration port of a two-channel full-bridge motor driver. A host writes it over three wires: a serial clock, a data line and a latch strobe. Frames are 19 bits long and are sent most-significant bit first. On the rising edge of the strobe, the low bit of the frame chooses which of two holding registers receives the other 18 bits.

The first holding register drives the bridges. For each bridge it gives a 6-bit current-level code, a polarity bit and a decay-mode bit. It also holds one bit that selects the reference source and one bit that selects the current scaling range. From each code and polarity bit the block makes a pair of high/low drive requests and an enable flag. A code of zero turns that bridge fully off. The second holding register is only stored and shown on an output bus.

The three serial wires come from outside and are asynchronous to the core clock. Each wire passes through a synchronizer before its edges are detected in the core clock domain.

Top module: `serialBridgeCfg`

## Requirements
- R1: After reset every output is 0: both codes, drive requests, enables, decay bits, reference, range and the stored second word.
- R2: Each synchronized rising edge of serClk shifts serData into bit 0 of a 19-bit shift register, so the first bit sent ends up as bit 18. Frames with more or fewer than 19 bits leave only the last 19 bits shifted in.
- R3: At a latch, shift bit 0 = 0 loads bits 18:1 into the first word and bit 0 = 1 loads them into the second word, shown on auxWord[17:0]. The word that is not selected does not change.
- R4: First-word bits 6:1 are the bridge 1 code on currentCode[5:0], and bits 12:7 are the bridge 2 code on currentCode[11:6]. The lowest bit of each field is the LSB.
- R5: Bit 13 sets the polarity of bridge 1 and bit 14 sets bridge 2. When the bridge is enabled, polarity 1 gives drvA=1, drvB=0 and polarity 0 gives drvA=0, drvB=1. Index 0 is bridge 1.
- R6: Bits 15 and 16 appear on slowDecay[0] and slowDecay[1]. A value of 1 means slow decay and 0 means mixed decay.
- R7: Bit 17 appears on extRef (1 = external reference). Bit 18 appears on quarterScale (1 = one-quarter divider, 0 = one-eighth).
- R8: A bridge whose code is all zeros has bridgeEn=0, drvA=0 and drvB=0, whatever its polarity bit says. Otherwise bridgeEn=1.
- R9: The decoded outputs and auxWord change only at a latch. The load takes effect at the third rising clk edge after serLatch goes high. The serial clock and data are sampled with the same two-stage delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLatch | input | 1 | Latch strobe, acts on its rising edge |
| currentCode | output | 12 | Current codes, bridge 1 in bits 5:0 |
| drvA | output | 2 | Output A high request per bridge |
| drvB | output | 2 | Output B high request per bridge |
| bridgeEn | output | 2 | Bridge enable per bridge |
| slowDecay | output | 2 | 1 = slow decay, 0 = mixed |
| extRef | output | 1 | 1 = external reference |
| quarterScale | output | 1 | 1 = quarter divider, 0 = eighth |
| auxWord | output | 18 | Stored second word, bits 18:1 of its frame |

## Verification
A pin change reaches the edge detector after two synchronizer flops. The rising edge is therefore acted on at the third clk edge after the pin rises, and the decoded outputs follow combinationally from the holding register. The bench models this with a history of pin samples taken at each rising clk edge. It applies a shift or load using the samples from two and three edges earlier, and compares every output at the following falling edge. For a scenario check, the bench raises the latch and confirms the old values after two edges and the new values after the third. All other scenario checks are made only after the serial pins have been held still for at least four clocks.

// File: rtl/bridgeCfgPkg.sv
package bridgeCfgPkg;
  // strobes from serial control to the register datapath
  typedef struct packed {
    logic shiftEn;
    logic bitIn;
    logic loadEn;
  } ctlStrobe_t;
endpackage

// File: rtl/serialFront.sv
module serialFront
  import bridgeCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serLatch,
  output ctlStrobe_t strobes
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync;
  logic [TOP:0] dataSync;
  logic [TOP:0] latchSync;
  logic         clkPrev;
  logic         latchPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkSync   <= '0;
      dataSync  <= '0;
      latchSync <= '0;
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      clkSync   <= {clkSync[TOP-1:0], serClk};
      dataSync  <= {dataSync[TOP-1:0], serData};
      latchSync <= {latchSync[TOP-1:0], serLatch};
      clkPrev   <= clkSync[TOP];
      latchPrev <= latchSync[TOP];
    end
  end

  always_comb begin
    strobes.shiftEn = clkSync[TOP] & ~clkPrev;
    strobes.bitIn   = dataSync[TOP];
    strobes.loadEn  = latchSync[TOP] & ~latchPrev;
  end
endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import bridgeCfgPkg::*;
#(
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobes,
  output logic [WORD_W-1:0] shiftVal,
  output logic [WORD_W-2:0] word0,
  output logic [WORD_W-2:0] word1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftVal <= '0;
      word0    <= '0;
      word1    <= '0;
    end else begin
      if (strobes.loadEn) begin
        if (shiftVal[0]) word1 <= shiftVal[WORD_W-1:1];
        else             word0 <= shiftVal[WORD_W-1:1];
      end
      if (strobes.shiftEn) shiftVal <= {shiftVal[WORD_W-2:0], strobes.bitIn};
    end
  end
endmodule

// File: rtl/bridgeDecode.sv
module bridgeDecode #(
  parameter int CODE_W = 6,
  parameter int NUM_BR = 2
) (
  input  logic [NUM_BR*(CODE_W+2)+1:0] cfg,
  output logic [NUM_BR*CODE_W-1:0]     currentCode,
  output logic [NUM_BR-1:0]            drvA,
  output logic [NUM_BR-1:0]            drvB,
  output logic [NUM_BR-1:0]            bridgeEn,
  output logic [NUM_BR-1:0]            slowDecay,
  output logic                         extRef,
  output logic                         quarterScale
);
  localparam int DIR_BASE   = NUM_BR * CODE_W;
  localparam int DECAY_BASE = DIR_BASE + NUM_BR;
  localparam int REF_POS    = DECAY_BASE + NUM_BR;

  for (genvar i = 0; i < NUM_BR; i++) begin : g_bridge
    logic [CODE_W-1:0] code;
    logic              polarity;
    logic              live;
    assign code     = cfg[i*CODE_W +: CODE_W];
    assign polarity = cfg[DIR_BASE + i];
    assign live     = |code;
    assign currentCode[i*CODE_W +: CODE_W] = code;
    assign bridgeEn[i]  = live;
    assign drvA[i]      = live & polarity;
    assign drvB[i]      = live & ~polarity;
    assign slowDecay[i] = cfg[DECAY_BASE + i];
  end

  assign extRef       = cfg[REF_POS];
  assign quarterScale = cfg[REF_POS + 1];
endmodule

// File: rtl/serialBridgeCfg.sv
module serialBridgeCfg
  import bridgeCfgPkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int NUM_BR      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       serLatch,
  output logic [NUM_BR*CODE_W-1:0]   currentCode,
  output logic [NUM_BR-1:0]          drvA,
  output logic [NUM_BR-1:0]          drvB,
  output logic [NUM_BR-1:0]          bridgeEn,
  output logic [NUM_BR-1:0]          slowDecay,
  output logic                       extRef,
  output logic                       quarterScale,
  output logic [NUM_BR*(CODE_W+2)+1:0] auxWord
);
  localparam int WORD_W = NUM_BR * (CODE_W + 2) + 3;

  ctlStrobe_t        strobes;
  logic [WORD_W-1:0] shiftVal;
  logic [WORD_W-2:0] word0;

  serialFront #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .strobes(strobes)
  );

  regDatapath #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .shiftVal(shiftVal),
    .word0(word0), .word1(auxWord)
  );

  bridgeDecode #(.CODE_W(CODE_W), .NUM_BR(NUM_BR)) u_decode (
    .cfg(word0), .currentCode(currentCode), .drvA(drvA), .drvB(drvB),
    .bridgeEn(bridgeEn), .slowDecay(slowDecay), .extRef(extRef),
    .quarterScale(quarterScale)
  );
endmodule

// File: rtl/bridgeCfgChecker.sv
module bridgeCfgChecker
  import bridgeCfgPkg::*;
#(
  parameter int CODE_W = 6,
  parameter int NUM_BR = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input ctlStrobe_t                   strobes,
  input logic [NUM_BR*(CODE_W+2)+2:0] shiftVal,
  input logic [NUM_BR*CODE_W-1:0]     currentCode,
  input logic [NUM_BR-1:0]            drvA,
  input logic [NUM_BR-1:0]            drvB,
  input logic [NUM_BR-1:0]            bridgeEn,
  input logic [NUM_BR-1:0]            slowDecay,
  input logic                         extRef,
  input logic                         quarterScale,
  input logic [NUM_BR*(CODE_W+2)+1:0] auxWord
);
  for (genvar i = 0; i < NUM_BR; i++) begin : g_chk
    a_r8_zero_code_off: assert property (@(posedge clk) disable iff (!rst_n)
      (currentCode[i*CODE_W +: CODE_W] == '0) |-> (!drvA[i] && !drvB[i] && !bridgeEn[i]));
    a_r5_complementary: assert property (@(posedge clk) disable iff (!rst_n)
      bridgeEn[i] |-> (drvA[i] != drvB[i]));
  end

  a_r9_hold_without_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.loadEn |=> $stable({currentCode, drvA, drvB, slowDecay, extRef, quarterScale, auxWord}));

  a_r3_word1_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadEn && !shiftVal[0]) |=> $stable(auxWord));

  a_r3_word0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.loadEn && shiftVal[0]) |=> $stable({currentCode, slowDecay, extRef, quarterScale}));

  a_r2_shift_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.shiftEn |=> (shiftVal[0] == $past(strobes.bitIn)));
endmodule

bind serialBridgeCfg bridgeCfgChecker #(.CODE_W(CODE_W), .NUM_BR(NUM_BR)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobes(strobes), .shiftVal(shiftVal),
  .currentCode(currentCode), .drvA(drvA), .drvB(drvB), .bridgeEn(bridgeEn),
  .slowDecay(slowDecay), .extRef(extRef), .quarterScale(quarterScale),
  .auxWord(auxWord)
);

// File: tb/serialBridgeCfg_bench.sv
module serialBridgeCfg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic [11:0] currentCode;
  logic [1:0]  drvA, drvB, bridgeEn, slowDecay;
  logic        extRef, quarterScale;
  logic [17:0] auxWord;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  serialBridgeCfg u_serialBridgeCfg (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .currentCode(currentCode), .drvA(drvA), .drvB(drvB),
    .bridgeEn(bridgeEn), .slowDecay(slowDecay), .extRef(extRef),
    .quarterScale(quarterScale), .auxWord(auxWord)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full 19-bit first-word image, checked by literal field positions
  task automatic checkWord0(input logic [18:0] w);
    logic en1, en2;
    en1 = |w[6:1];
    en2 = |w[12:7];
    chk("R4 bridge1 code", currentCode[5:0], w[6:1]);
    chk("R4 bridge2 code", currentCode[11:6], w[12:7]);
    chk("R8 enables", bridgeEn, {en2, en1});
    chk("R5 drvA", drvA, {en2 & w[14], en1 & w[13]});
    chk("R5 drvB", drvB, {en2 & ~w[14], en1 & ~w[13]});
    chk("R6 decay", slowDecay, w[16:15]);
    chk("R7 reference", extRef, w[17]);
    chk("R7 range", quarterScale, w[18]);
  endtask

  // behavioural reference: pin samples history, acts two edges late
  logic [18:0] mShift, mW0;
  logic [17:0] mW1;
  logic [2:0]  hist[$];
  always @(posedge clk) begin
    logic [2:0] a, b;
    if (!rst_n) begin
      mShift = '0; mW0 = '0; mW1 = '0;
      hist.delete();
    end else begin
      hist.push_front({serClk, serData, serLatch});
      a = (hist.size() > 2) ? hist[2] : 3'b000;
      b = (hist.size() > 3) ? hist[3] : 3'b000;
      if (a[0] && !b[0]) begin
        if (mShift[0]) mW1 = mShift[18:1];
        else           mW0 = {mShift[18:1], 1'b0};
      end
      if (a[2] && !b[2]) mShift = {mShift[17:0], a[1]};
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checkWord0(mW0);
      chk("R3 second word", auxWord, mW1);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk);
    serData = b;
    idle(3);
    serClk = 1'b1;
    idle(3);
    serClk = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shiftBit(v[i]);
    idle(4);
  endtask

  task automatic latch();
    @(negedge clk);
    serLatch = 1'b1;
    idle(3);
    serLatch = 1'b0;
    idle(4);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [18:0] w2, w4, w5, w6, s7;
    logic [9:0]  v10;
    w2  = (19'd5 << 1) | (19'd40 << 7) | (19'd1 << 13) | (19'd1 << 15) | (19'd1 << 17);
    w4  = {18'h2A5A5, 1'b1};
    w5  = (19'd63 << 7) | (19'd1 << 13) | (19'd1 << 14) | (19'd1 << 16) | (19'd1 << 18);
    w6  = (19'd33 << 1) | (19'd1 << 7) | (19'd1 << 14) | (19'd1 << 15) | (19'd1 << 17) | (19'd1 << 18);
    v10 = 10'b1011001100;
    s7  = {w6[8:0], v10};

    idle(3);
    // R1: reset state
    checkWord0(19'd0);
    chk("R1 second word", auxWord, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    checkWord0(19'd0);

    // R2/R9: write first word, check load lands on third edge
    sendBits({13'd0, w2}, 19);
    @(negedge clk);
    serLatch = 1'b1;
    idle(2);
    chk("R9 not yet loaded", bridgeEn, 2'b00);
    idle(1);
    chk("R9 loaded on third edge", currentCode, {w2[12:7], w2[6:1]});
    serLatch = 1'b0;
    idle(4);
    checkWord0(w2);

    // R9: shifting without latch changes nothing
    sendBits({13'd0, w4}, 19);
    checkWord0(w2);
    chk("R9 no latch second word", auxWord, 18'd0);

    // R3: bit0=1 routes to second word, first untouched
    latch();
    chk("R3 second word loaded", auxWord, w4[18:1]);
    checkWord0(w2);

    // R8/R5/R7: bridge 1 off with polarity 1, bridge 2 full
    sendBits({13'd0, w5}, 19);
    latch();
    checkWord0(w5);
    chk("R8 bridge1 off", {drvA[0], drvB[0], bridgeEn[0]}, 3'b000);
    chk("R3 second word kept", auxWord, w4[18:1]);

    // R2: over-long frame keeps last 19 bits
    sendBits({9'd0, 4'hF, w6}, 23);
    latch();
    checkWord0(w6);

    // R2: short frame merges with earlier bits
    sendBits({22'd0, v10}, 10);
    latch();
    checkWord0({s7[18:1], 1'b0});
    chk("R2 short frame second word", auxWord, w4[18:1]);

    idle(5);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule